// File: doc/BRIEF.md
# Dual-Channel Latched Bus Transceiver

This block is a clocked model of a two-way bus transceiver. It has two independent 8-bit channels, and each channel moves data in both directions: from side A to side B and from side B to side A. Each direction has three active-low controls: a direction enable, a latch enable and an output enable. Each direction also has one data latch, which is either transparent or holding.

Every input is sampled on the rising edge of the system clock, and all outputs are registered. Each side presents a data bus and a drive-enable bit for each channel, so the block needs no tristate pins. The surrounding logic decides how to merge the data buses onto a shared wire.

When a channel drives both sides in the same cycle, the block raises a contention flag for that channel. It does not resolve the conflict.

Top module: `dual_latched_xcvr`

## Requirements
- R1: A synchronous active-high reset clears both stored latches of every channel to zero. It also clears every drive enable, data output and contention flag. After reset, a holding latch that is driven presents 0x00.
- R2: Each channel reacts only to its own controls and data. Controls are active low (0 = asserted). Bits [8c+7:8c] of every data bus belong to channel c.
- R3: When a direction's enable, latch enable and output enable are all sampled low, the destination bus shows the source data from that same edge one cycle later.
- R4: When the latch enable is sampled high with the enable low, the latch holds the value from the last transparent sample. Source data presented while holding has no effect on the destination bus.
- R5: When the direction enable is sampled high, the latch holds no matter what the latch enable is. The destination is not driven in that case.
- R6: A destination drive enable is 1 exactly when the direction enable and output enable were both low at the previous edge. While its drive enable is 0, a destination data bus reads 0x00.
- R7: A transparent latch keeps updating while its output enable is high. Once the output is enabled, it shows the last value taken.
- R8: The B-to-A direction, with destination bus aOut and drive bit aDrive, behaves exactly like the A-to-B direction, using its own three controls.
- R9: A channel's contention bit is 1 exactly when both of its drive enables are 1.
- R10: Every output changes only at a clock edge, one cycle after the inputs that cause the change.

Top module ports are listed below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| aIn | input | 16 | Side A data in, 8 bits per channel |
| bIn | input | 16 | Side B data in, 8 bits per channel |
| enAbN | input | 2 | A-to-B direction enable per channel, active low |
| leAbN | input | 2 | A-to-B latch enable per channel, active low |
| oeAbN | input | 2 | A-to-B output enable per channel, active low |
| enBaN | input | 2 | B-to-A direction enable per channel, active low |
| leBaN | input | 2 | B-to-A latch enable per channel, active low |
| oeBaN | input | 2 | B-to-A output enable per channel, active low |
| aOut | output | 16 | Data presented on side A (B-to-A result) |
| aDrive | output | 2 | Side A drive enable per channel |
| bOut | output | 16 | Data presented on side B (A-to-B result) |
| bDrive | output | 2 | Side B drive enable per channel |
| contention | output | 2 | Both sides of a channel driven at once |

## Verification
The assertions check four rules on every cycle:
- Drive enables follow the previous edge's enables.
- Undriven buses read zero.
- A transparent sample shows up one cycle later.
- A driven holding latch keeps its output steady.

They also tie the contention flag to the two drive bits. Only the bench's scenarios can show that the value frozen at a latch-enable rise is the last transparent one, and that a latch keeps filling while its output is disabled. The same goes for a latch holding across a period with its enable high, and for the two channels staying isolated. These properties depend on history longer than one cycle.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  typedef struct packed {
    logic loadAb;
    logic driveAb;
    logic loadBa;
    logic driveBa;
  } chanStrobe_t;
endpackage

// File: rtl/xcvr_ctrl.sv
module xcvr_ctrl
  import xcvr_pkg::*;
#(
  parameter int NUM_CH = 2
) (
  input  logic [NUM_CH-1:0]              enAbN,
  input  logic [NUM_CH-1:0]              leAbN,
  input  logic [NUM_CH-1:0]              oeAbN,
  input  logic [NUM_CH-1:0]              enBaN,
  input  logic [NUM_CH-1:0]              leBaN,
  input  logic [NUM_CH-1:0]              oeBaN,
  output chanStrobe_t [NUM_CH-1:0]       strobes
);
  // Decode the active-low controls into strobes for each channel.
  // A latch loads only when its enable and latch enable are both asserted.
  // A side is driven only when its enable and output enable are both asserted.
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    always_comb begin
      strobes[c].loadAb  = ~enAbN[c] & ~leAbN[c];
      strobes[c].driveAb = ~enAbN[c] & ~oeAbN[c];
      strobes[c].loadBa  = ~enBaN[c] & ~leBaN[c];
      strobes[c].driveBa = ~enBaN[c] & ~oeBaN[c];
    end
  end
endmodule

// File: rtl/xcvr_datapath.sv
module xcvr_datapath
  import xcvr_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int WIDTH  = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  chanStrobe_t [NUM_CH-1:0]    strobes,
  input  logic [NUM_CH*WIDTH-1:0]     aIn,
  input  logic [NUM_CH*WIDTH-1:0]     bIn,
  output logic [NUM_CH*WIDTH-1:0]     aOut,
  output logic [NUM_CH-1:0]           aDrive,
  output logic [NUM_CH*WIDTH-1:0]     bOut,
  output logic [NUM_CH-1:0]           bDrive,
  output logic [NUM_CH-1:0]           contention
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam int LO = c * WIDTH;

    logic [WIDTH-1:0] storeAb, storeBa;
    logic [WIDTH-1:0] nextAb, nextBa;

    // The next latch content is also the value that goes out when the side is driven.
    assign nextAb = strobes[c].loadAb ? aIn[LO +: WIDTH] : storeAb;
    assign nextBa = strobes[c].loadBa ? bIn[LO +: WIDTH] : storeBa;

    always_ff @(posedge clk) begin
      if (rst) begin
        storeAb       <= '0;
        storeBa       <= '0;
        bOut[LO +: WIDTH] <= '0;
        aOut[LO +: WIDTH] <= '0;
        bDrive[c]     <= 1'b0;
        aDrive[c]     <= 1'b0;
        contention[c] <= 1'b0;
      end else begin
        storeAb       <= nextAb;
        storeBa       <= nextBa;
        bOut[LO +: WIDTH] <= strobes[c].driveAb ? nextAb : '0;
        aOut[LO +: WIDTH] <= strobes[c].driveBa ? nextBa : '0;
        bDrive[c]     <= strobes[c].driveAb;
        aDrive[c]     <= strobes[c].driveBa;
        contention[c] <= strobes[c].driveAb & strobes[c].driveBa;
      end
    end
  end
endmodule

// File: rtl/dual_latched_xcvr.sv
module dual_latched_xcvr
  import xcvr_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int WIDTH  = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NUM_CH*WIDTH-1:0]  aIn,
  input  logic [NUM_CH*WIDTH-1:0]  bIn,
  input  logic [NUM_CH-1:0]        enAbN,
  input  logic [NUM_CH-1:0]        leAbN,
  input  logic [NUM_CH-1:0]        oeAbN,
  input  logic [NUM_CH-1:0]        enBaN,
  input  logic [NUM_CH-1:0]        leBaN,
  input  logic [NUM_CH-1:0]        oeBaN,
  output logic [NUM_CH*WIDTH-1:0]  aOut,
  output logic [NUM_CH-1:0]        aDrive,
  output logic [NUM_CH*WIDTH-1:0]  bOut,
  output logic [NUM_CH-1:0]        bDrive,
  output logic [NUM_CH-1:0]        contention
);
  chanStrobe_t [NUM_CH-1:0] strobes;

  xcvr_ctrl #(.NUM_CH(NUM_CH)) u_ctrl (
    .enAbN(enAbN), .leAbN(leAbN), .oeAbN(oeAbN),
    .enBaN(enBaN), .leBaN(leBaN), .oeBaN(oeBaN),
    .strobes(strobes)
  );

  xcvr_datapath #(.NUM_CH(NUM_CH), .WIDTH(WIDTH)) u_dp (
    .clk(clk), .rst(rst), .strobes(strobes),
    .aIn(aIn), .bIn(bIn),
    .aOut(aOut), .aDrive(aDrive),
    .bOut(bOut), .bDrive(bDrive),
    .contention(contention)
  );
endmodule

// File: rtl/dual_latched_xcvr_chk.sv
module dual_latched_xcvr_chk #(
  parameter int NUM_CH = 2,
  parameter int WIDTH  = 8
) (
  input logic                     clk,
  input logic                     rst,
  input logic [NUM_CH*WIDTH-1:0]  aIn,
  input logic [NUM_CH*WIDTH-1:0]  bIn,
  input logic [NUM_CH-1:0]        enAbN,
  input logic [NUM_CH-1:0]        leAbN,
  input logic [NUM_CH-1:0]        oeAbN,
  input logic [NUM_CH-1:0]        enBaN,
  input logic [NUM_CH-1:0]        leBaN,
  input logic [NUM_CH-1:0]        oeBaN,
  input logic [NUM_CH*WIDTH-1:0]  aOut,
  input logic [NUM_CH-1:0]        aDrive,
  input logic [NUM_CH*WIDTH-1:0]  bOut,
  input logic [NUM_CH-1:0]        bDrive,
  input logic [NUM_CH-1:0]        contention
);
  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (aDrive == '0 && bDrive == '0 && contention == '0)); // R1

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam int LO = c * WIDTH;

    AST_B_DRIVE_RULE: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> bDrive[c] == $past(~enAbN[c] & ~oeAbN[c])); // R6
    AST_A_DRIVE_RULE: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> aDrive[c] == $past(~enBaN[c] & ~oeBaN[c])); // R8
    AST_B_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
      !bDrive[c] |-> bOut[LO +: WIDTH] == '0); // R6
    AST_A_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
      !aDrive[c] |-> aOut[LO +: WIDTH] == '0); // R8
    AST_B_PASS_THROUGH: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(!enAbN[c] && !leAbN[c] && !oeAbN[c]))
        |-> bOut[LO +: WIDTH] == $past(aIn[LO +: WIDTH])); // R3
    AST_A_PASS_THROUGH: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(!enBaN[c] && !leBaN[c] && !oeBaN[c]))
        |-> aOut[LO +: WIDTH] == $past(bIn[LO +: WIDTH])); // R8
    AST_B_HOLD_STEADY: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(enAbN[c] | leAbN[c]) && $past(bDrive[c]) && bDrive[c])
        |-> $stable(bOut[LO +: WIDTH])); // R4
    AST_CONTENTION_MATCH: assert property (@(posedge clk) disable iff (rst)
      contention[c] == (aDrive[c] & bDrive[c])); // R9
  end
endmodule

bind dual_latched_xcvr dual_latched_xcvr_chk #(.NUM_CH(NUM_CH), .WIDTH(WIDTH)) u_chk (.*);

// File: tb/dual_latched_xcvr_test.sv
module dual_latched_xcvr_test;
  localparam int N = 2;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N*W-1:0] aIn = '0, bIn = '0;
  logic [N-1:0] enAbN = '1, leAbN = '1, oeAbN = '1;
  logic [N-1:0] enBaN = '1, leBaN = '1, oeBaN = '1;
  logic [N*W-1:0] aOut, bOut;
  logic [N-1:0] aDrive, bDrive, contention;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  // Behavioural reference state
  logic [W-1:0] mStoreAb[N], mStoreBa[N], mB[N], mA[N];
  logic mDb[N], mDa[N], mCon[N];

  always #5 clk = ~clk;

  dual_latched_xcvr uut (
    .clk(clk), .rst(rst), .aIn(aIn), .bIn(bIn),
    .enAbN(enAbN), .leAbN(leAbN), .oeAbN(oeAbN),
    .enBaN(enBaN), .leBaN(leBaN), .oeBaN(oeBaN),
    .aOut(aOut), .aDrive(aDrive), .bOut(bOut), .bDrive(bDrive),
    .contention(contention)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic modelUpdate();
    for (int c = 0; c < N; c++) begin
      if (rst) begin
        mStoreAb[c] = '0; mStoreBa[c] = '0; mB[c] = '0; mA[c] = '0;
        mDb[c] = 0; mDa[c] = 0; mCon[c] = 0;
      end else begin
        if (!enAbN[c] && !leAbN[c]) mStoreAb[c] = aIn[c*W +: W];
        if (!enBaN[c] && !leBaN[c]) mStoreBa[c] = bIn[c*W +: W];
        mDb[c] = !enAbN[c] && !oeAbN[c];
        mDa[c] = !enBaN[c] && !oeBaN[c];
        mB[c] = mDb[c] ? mStoreAb[c] : '0;
        mA[c] = mDa[c] ? mStoreBa[c] : '0;
        mCon[c] = mDb[c] && mDa[c];
      end
    end
  endtask

  // One clock: model at the edge, compare every output half a cycle later
  task automatic step(input string req);
    @(posedge clk);
    modelUpdate();
    @(negedge clk);
    for (int c = 0; c < N; c++) begin
      chk(req, $sformatf("ch%0d bOut", c), bOut[c*W +: W], mB[c]);
      chk(req, $sformatf("ch%0d bDrive", c), bDrive[c], mDb[c]);
      chk(req, $sformatf("ch%0d aOut", c), aOut[c*W +: W], mA[c]);
      chk(req, $sformatf("ch%0d aDrive", c), aDrive[c], mDa[c]);
      chk(req, $sformatf("ch%0d contention", c), contention[c], mCon[c]);
    end
  endtask

  task automatic setAb(input int c, input bit en, input bit le, input bit oe, input logic [W-1:0] d);
    enAbN[c] = en; leAbN[c] = le; oeAbN[c] = oe; aIn[c*W +: W] = d;
  endtask

  task automatic setBa(input int c, input bit en, input bit le, input bit oe, input logic [W-1:0] d);
    enBaN[c] = en; leBaN[c] = le; oeBaN[c] = oe; bIn[c*W +: W] = d;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] lfsr;
    @(negedge clk);
    step("R1"); step("R1");
    // Controls are active during reset; nothing may leak out.
    setAb(0, 0, 0, 0, 8'hAA);
    step("R1");
    chk("R1", "bDrive during reset", bDrive[0], 0);
    rst = 0;
    setAb(0, 0, 1, 0, 8'hEE);
    step("R1");
    chk("R1", "held value after reset", bOut[W-1:0], 8'h00);

    setAb(0, 0, 0, 0, 8'h5A); step("R3");
    chk("R3", "transparent 5A", bOut[W-1:0], 8'h5A);
    chk("R2", "ch1 untouched", bDrive[1], 0);
    setAb(0, 0, 0, 0, 8'hC3); step("R3");
    setAb(0, 0, 0, 0, 8'h3C); step("R4");
    setAb(0, 0, 1, 0, 8'hFF); step("R4");
    chk("R4", "frozen at 3C", bOut[W-1:0], 8'h3C);
    setAb(0, 0, 1, 0, 8'h11); step("R4");

    setAb(0, 1, 0, 0, 8'h77); step("R5");
    chk("R5", "disabled not driven", bDrive[0], 0);
    setAb(0, 0, 1, 0, 8'h22); step("R5");
    chk("R5", "kept 3C across disable", bOut[W-1:0], 8'h3C);

    setAb(0, 0, 0, 1, 8'h99); step("R6");
    chk("R6", "oe high output zero", bOut[W-1:0], 8'h00);
    setAb(0, 0, 1, 0, 8'h44); step("R7");
    chk("R7", "latched while oe high", bOut[W-1:0], 8'h99);

    setAb(0, 1, 1, 1, 8'h00);
    setBa(1, 0, 0, 0, 8'hB7); step("R8");
    chk("R8", "B to A transparent", aOut[2*W-1:W], 8'hB7);
    setBa(1, 0, 1, 0, 8'h01); step("R8");
    chk("R8", "B to A held", aOut[2*W-1:W], 8'hB7);
    chk("R2", "ch0 quiet", aDrive[0] | bDrive[0], 0);

    setAb(1, 0, 0, 0, 8'h6D); step("R9");
    chk("R9", "ch1 contention", contention[1], 1);
    chk("R9", "ch0 no contention", contention[0], 0);

    lfsr = 32'hACE1_2357;
    for (int i = 0; i < 300; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      {enAbN, leAbN, oeAbN, enBaN, leBaN, oeBaN} = lfsr[11:0];
      enAbN = enAbN & {lfsr[13], lfsr[12]};
      enBaN = enBaN & {lfsr[15], lfsr[14]};
      aIn = lfsr[31:16] ^ 16'(i);
      bIn = lfsr[23:8];
      step("R10");
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule